// File: doc/BRIEF.md
# Command Stream Method Decoder

The block sits behind a fetch unit that has already read a command list from memory. It takes the list one 32-bit word at a time and turns it into single register writes for downstream engines. Each write carries a 13-bit method address, a 3-bit subchannel and a 32-bit value. A list starts with a one-cycle start pulse that carries the list length in words. The decoder then reads a header word. It issues the writes that the header describes and consumes any payload words that follow. When the word budget of the list runs out, it returns to idle.

Each header selects how the method address moves from one payload word to the next. In incrementing modes the method steps by one for each word. In fixed modes it stays the same. In increment-once mode only the first step is taken. In inline mode the header carries a 13-bit immediate, produces one write and consumes no payload word. Malformed headers and lists that end in the middle of a payload set error flags. Both flags hold until the next list starts.

Top module: `cmd_stream_decoder`

## Requirements
- R1: A header word is split as method = bits 12:0, subchannel = bits 15:13, count = bits 28:16, mode = bits 31:29. Every write produced from a header carries that header's subchannel on `wr_subch_o`.
- R2: Modes 0 and 1 write payload word k (k counting from 0) to method+k. The sum wraps within 13 bits.
- R3: Modes 2 and 3 write every payload word to the header's method.
- R4: Mode 5 writes payload word 0 to the method and every later payload word to method+1 (13-bit wrap).
- R5: Mode 4 issues exactly one write to the method. Its value is bits 28:16 of the header, zero-extended to 32 bits. It consumes no payload word.
- R6: A header with mode 6 or 7, or with mode 5 and a count of 0, sets `err_mode_o` and issues no write. The next word is then read as a header. `err_mode_o` stays set until the next accepted start.
- R7: Headers and payload words both use up the `len_i` budget. Exactly `len_i` words are accepted, after which `busy_o` falls. With `len_i` = 0 no word is accepted. `word_ready_o` is low while idle. A header in modes 0 to 3 with a count of 0 issues no write.
- R8: If the budget ends before a header's payload is complete, the writes for the words received are still issued. `err_trunc_o` is then set and the decoder returns to idle.
- R9: While `wr_valid_o` is high and `wr_ready_i` is low, the write outputs stay unchanged. No word is accepted unless the output slot is free or draining. No write is lost or duplicated.
- R10: After reset, `busy_o`, `word_ready_o`, `wr_valid_o`, `err_mode_o` and `err_trunc_o` are all low.
- R11: A start pulse accepted while idle clears both error flags. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | List start pulse, honoured while idle |
| len_i | input | LEN_W | List length in words, sampled with start_i |
| word_valid_i | input | 1 | Command word valid |
| word_ready_o | output | 1 | Command word accepted when high with valid |
| word_i | input | 32 | Command word |
| wr_valid_o | output | 1 | Register write valid |
| wr_ready_i | input | 1 | Register write accepted |
| wr_method_o | output | 13 | Method address of the write |
| wr_subch_o | output | 3 | Subchannel of the write |
| wr_value_o | output | 32 | Data of the write |
| busy_o | output | 1 | A list is being decoded |
| err_mode_o | output | 1 | Sticky malformed-header flag |
| err_trunc_o | output | 1 | Sticky truncated-payload flag |

## Verification
The hardest case to reach is a payload write that stalls in the output register at the moment the list budget runs out mid-payload. The stall must not drop that write, and the truncation flag must still come up. Directed lists are cut short inside a payload, and random lists are sometimes trimmed by one or two words. In both kinds the write-ready line and the word-valid line are toggled at random, so stalls land on the final words. The same randomised handshakes also stall the incrementing sequences across the 13-bit wrap and across the increment-once step.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam int WORD_W    = 32;
  localparam int METH_W    = 13;
  localparam int SUBCH_W   = 3;
  localparam int CNT_W     = 13;
  localparam int MODE_W    = 3;
  localparam int METH_LSB  = 0;
  localparam int SUBCH_LSB = METH_LSB + METH_W;
  localparam int CNT_LSB   = SUBCH_LSB + SUBCH_W;
  localparam int MODE_LSB  = CNT_LSB + CNT_W;

  typedef enum logic [2:0] {K_INC, K_FIX, K_ONCE, K_INLINE, K_BAD} kind_e;

  typedef struct packed {
    kind_e               kind;
    logic [CNT_W-1:0]    cnt;
    logic [SUBCH_W-1:0]  subch;
    logic [METH_W-1:0]   method;
  } hdr_t;
endpackage

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode
  import cmd_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output hdr_t              hdr_o
);
  logic [MODE_W-1:0] mode;

  always_comb begin
    mode         = word_i[MODE_LSB +: MODE_W];
    hdr_o.method = word_i[METH_LSB +: METH_W];
    hdr_o.subch  = word_i[SUBCH_LSB +: SUBCH_W];
    hdr_o.cnt    = word_i[CNT_LSB +: CNT_W];
    unique case (mode)
      3'd0, 3'd1: hdr_o.kind = K_INC;
      3'd2, 3'd3: hdr_o.kind = K_FIX;
      3'd4:       hdr_o.kind = K_INLINE;
      3'd5:       hdr_o.kind = (hdr_o.cnt == '0) ? K_BAD : K_ONCE;
      default:    hdr_o.kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/cmd_budget.sv
module cmd_budget #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [LEN_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= len_i;
    else if (dec_i)  rem_q <= rem_q - {{(LEN_W-1){1'b0}}, 1'b1};
  end

  assign last_o = (rem_q == {{(LEN_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/cmd_method_seq.sv
module cmd_method_seq
  import cmd_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [METH_W-1:0] method_i,
  input  kind_e             kind_i,
  input  logic              step_i,
  output logic [METH_W-1:0] method_o
);
  logic [METH_W-1:0] cur_q;
  kind_e             kind_q;
  logic              first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      kind_q  <= K_FIX;
      first_q <= 1'b0;
    end else if (load_i) begin
      cur_q   <= method_i;
      kind_q  <= kind_i;
      first_q <= 1'b1;
    end else if (step_i) begin
      first_q <= 1'b0;
      if (kind_q == K_INC || (kind_q == K_ONCE && first_q))
        cur_q <= cur_q + {{(METH_W-1){1'b0}}, 1'b1};  // wraps in field
    end
  end

  assign method_o = cur_q;
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmd_dec_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               word_valid_i,
  output logic               word_ready_o,
  input  logic [WORD_W-1:0]  word_i,
  output logic               wr_valid_o,
  input  logic               wr_ready_i,
  output logic [METH_W-1:0]  wr_method_o,
  output logic [SUBCH_W-1:0] wr_subch_o,
  output logic [WORD_W-1:0]  wr_value_o,
  output logic               busy_o,
  output logic               err_mode_o,
  output logic               err_trunc_o
);
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_PAY} st_e;

  st_e                st_q;
  hdr_t               hdr;
  logic [CNT_W-1:0]   args_q;
  logic [SUBCH_W-1:0] subch_q;
  logic               last, out_free, acc, start_ok;
  logic               seq_load, seq_step, emit, hdr_has_pay;
  logic [METH_W-1:0]  seq_method, emit_method;
  logic [SUBCH_W-1:0] emit_subch;
  logic [WORD_W-1:0]  emit_value;

  cmd_hdr_decode i_dec (.word_i(word_i), .hdr_o(hdr));

  assign start_ok = start_i && (st_q == S_IDLE);

  cmd_budget #(.LEN_W(LEN_W)) i_budget (
    .clk_i, .rst_ni, .load_i(start_ok), .len_i, .dec_i(acc), .last_o(last)
  );

  cmd_method_seq i_seq (
    .clk_i, .rst_ni, .load_i(seq_load), .method_i(hdr.method), .kind_i(hdr.kind),
    .step_i(seq_step), .method_o(seq_method)
  );

  assign out_free     = !wr_valid_o || wr_ready_i;
  assign word_ready_o = (st_q != S_IDLE) && out_free;
  assign acc          = word_valid_i && word_ready_o;
  assign busy_o       = (st_q != S_IDLE);
  assign hdr_has_pay  = (hdr.kind == K_INC || hdr.kind == K_FIX || hdr.kind == K_ONCE)
                        && (hdr.cnt != '0);

  always_comb begin
    emit        = 1'b0;
    seq_load    = 1'b0;
    seq_step    = 1'b0;
    emit_method = hdr.method;
    emit_subch  = hdr.subch;
    emit_value  = {{(WORD_W-CNT_W){1'b0}}, hdr.cnt};
    if (acc && st_q == S_HDR) begin
      emit     = (hdr.kind == K_INLINE);
      seq_load = hdr_has_pay && !last;
    end
    if (acc && st_q == S_PAY) begin
      emit        = 1'b1;
      seq_step    = 1'b1;
      emit_method = seq_method;
      emit_subch  = subch_q;
      emit_value  = word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      args_q      <= '0;
      subch_q     <= '0;
      err_mode_o  <= 1'b0;
      err_trunc_o <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          err_mode_o  <= 1'b0;
          err_trunc_o <= 1'b0;
          st_q        <= (len_i != '0) ? S_HDR : S_IDLE;
        end
        S_HDR: if (acc) begin
          if (hdr.kind == K_BAD) err_mode_o <= 1'b1;
          if (hdr_has_pay) begin
            if (last) begin
              err_trunc_o <= 1'b1;
              st_q        <= S_IDLE;
            end else begin
              args_q  <= hdr.cnt;
              subch_q <= hdr.subch;
              st_q    <= S_PAY;
            end
          end else if (last) begin
            st_q <= S_IDLE;
          end
        end
        S_PAY: if (acc) begin
          args_q <= args_q - {{(CNT_W-1){1'b0}}, 1'b1};
          if (args_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
            st_q <= last ? S_IDLE : S_HDR;
          end else if (last) begin
            err_trunc_o <= 1'b1;
            st_q        <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // single-entry output register; refilled in the cycle it drains
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_o  <= 1'b0;
      wr_method_o <= '0;
      wr_subch_o  <= '0;
      wr_value_o  <= '0;
    end else if (emit) begin
      wr_valid_o  <= 1'b1;
      wr_method_o <= emit_method;
      wr_subch_o  <= emit_subch;
      wr_value_o  <= emit_value;
    end else if (wr_ready_i) begin
      wr_valid_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_dec_checker.sv
module cmd_dec_checker
  import cmd_dec_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               busy_o,
  input logic               word_ready_o,
  input logic               wr_valid_o,
  input logic               wr_ready_i,
  input logic [METH_W-1:0]  wr_method_o,
  input logic [SUBCH_W-1:0] wr_subch_o,
  input logic [WORD_W-1:0]  wr_value_o,
  input logic               err_mode_o,
  input logic               err_trunc_o
);
  p_hold_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_method_o)
                                  && $stable(wr_subch_o) && $stable(wr_value_o));

  p_ready_room_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |-> (!wr_valid_o || wr_ready_i));

  p_idle_no_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !word_ready_o);

  p_mode_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_mode_o && !start_i |=> err_mode_o);

  p_trunc_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_trunc_o) |-> !busy_o);

  p_start_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> !err_mode_o && !err_trunc_o);
endmodule

bind cmd_stream_decoder cmd_dec_checker i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .word_ready_o(word_ready_o), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
  .wr_method_o(wr_method_o), .wr_subch_o(wr_subch_o), .wr_value_o(wr_value_o),
  .err_mode_o(err_mode_o), .err_trunc_o(err_trunc_o)
);

// File: tb/test_cmd_stream_decoder.sv
`timescale 1ns/1ps
module test_cmd_stream_decoder;
  localparam int LEN_W = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] len_i = '0;
  logic        word_valid_i = 1'b0;
  logic        word_ready_o;
  logic [31:0] word_i = '0;
  logic        wr_valid_o;
  logic        wr_ready_i = 1'b0;
  logic [12:0] wr_method_o;
  logic [2:0]  wr_subch_o;
  logic [31:0] wr_value_o;
  logic        busy_o, err_mode_o, err_trunc_o;

  cmd_stream_decoder #(.LEN_W(LEN_W)) i_cmd_stream_decoder (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [31:0] lw [80];
  logic [47:0] exp_q[$];
  logic [47:0] got_q[$];
  bit exp_em, exp_et;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] hdr(int md, int cnt, int sc, int m);
    return {3'(md), 13'(cnt), 3'(sc), 13'(m)};
  endfunction

  // reference model from the requirement text
  task automatic model(int n);
    int i = 0;
    exp_q.delete();
    exp_em = 0;
    exp_et = 0;
    while (i < n) begin
      logic [31:0] h;
      logic [12:0] m, mm;
      logic [2:0]  sc, md;
      logic [12:0] c;
      h = lw[i]; i++;
      m = h[12:0]; sc = h[15:13]; c = h[28:16]; md = h[31:29];
      if (md >= 6 || (md == 5 && c == 0)) exp_em = 1;
      else if (md == 4) exp_q.push_back({sc, m, 19'b0, c});
      else begin
        for (int k = 0; k < int'(c); k++) begin
          if (i >= n) begin exp_et = 1; break; end
          if (md < 2)      mm = m + 13'(k);
          else if (md < 4) mm = m;
          else             mm = (k == 0) ? m : m + 13'd1;
          exp_q.push_back({sc, mm, lw[i]});
          i++;
        end
      end
    end
  endtask

  task automatic run_list(int n, int vp, int rp, string req);
    int idx = 0;
    int t = 0;
    model(n);
    got_q.delete();
    @(negedge clk_i);
    start_i = 1'b1;
    len_i = 16'(n);
    word_valid_i = 1'b0;
    forever begin
      @(negedge clk_i);
      start_i = 1'b0;
      word_valid_i = (idx < n) && ($urandom_range(0, 99) < vp);
      word_i = lw[idx];
      wr_ready_i = ($urandom_range(0, 99) < rp);
      #1;
      if (word_valid_i && word_ready_o) idx++;
      if (wr_valid_o && wr_ready_i) got_q.push_back({wr_subch_o, wr_method_o, wr_value_o});
      if (!busy_o && !wr_valid_o) break;
      t++;
      if (t > 4000) begin
        check(0, {req, " list timeout"}, 64'(t), 64'd4000);
        break;
      end
    end
    word_valid_i = 1'b0;
    check(idx == n, {req, " R7 words consumed"}, 64'(idx), 64'(n));
    check(got_q.size() == exp_q.size(), {req, " write count"}, 64'(got_q.size()), 64'(exp_q.size()));
    for (int k = 0; k < exp_q.size() && k < got_q.size(); k++)
      check(got_q[k] == exp_q[k], {req, " R1 write content"}, 64'(got_q[k]), 64'(exp_q[k]));
    check(err_mode_o == exp_em, {req, " R6 err_mode"}, 64'(err_mode_o), 64'(exp_em));
    check(err_trunc_o == exp_et, {req, " R8 err_trunc"}, 64'(err_trunc_o), 64'(exp_et));
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    word_valid_i = 1'b1;
    @(negedge clk_i); #1;
    // R10 reset state, R7 idle ignores words
    check(!busy_o && !wr_valid_o && !err_mode_o && !err_trunc_o, "R10 reset outputs",
          {busy_o, wr_valid_o, err_mode_o, err_trunc_o}, 64'd0);
    check(!word_ready_o, "R7 idle ready low", 64'(word_ready_o), 64'd0);
    word_valid_i = 1'b0;

    // R2 increment with wrap
    lw[0] = hdr(1, 3, 5, 13'h1FFE); lw[1] = 32'hA; lw[2] = 32'hB; lw[3] = 32'hC;
    run_list(4, 100, 100, "R2 incr wrap");
    // R3 fixed, R2 mode 0
    lw[0] = hdr(3, 2, 2, 13'h040); lw[1] = 32'h11; lw[2] = 32'h22;
    lw[3] = hdr(0, 1, 7, 13'h100); lw[4] = 32'h33;
    run_list(5, 70, 50, "R3 fixed");
    // R4 increment-once
    lw[0] = hdr(5, 3, 1, 13'h1FFF); lw[1] = 32'h1; lw[2] = 32'h2; lw[3] = 32'h3;
    run_list(4, 100, 30, "R4 once");
    // R5 inline then fixed
    lw[0] = hdr(4, 13'h1ABC, 4, 13'h055); lw[1] = hdr(2, 1, 3, 13'h066); lw[2] = 32'hDEAD_BEEF;
    run_list(3, 100, 40, "R5 inline");
    // R6 bad mode 7, decoding continues
    lw[0] = hdr(7, 2, 0, 13'h010); lw[1] = hdr(4, 13'h0005, 6, 13'h020);
    run_list(2, 100, 100, "R6 bad mode");
    // R6 once with zero count
    lw[0] = hdr(5, 0, 0, 13'h010);
    run_list(1, 100, 100, "R6 once zero");
    // R11 flags clear on next start; R7 count zero header
    lw[0] = hdr(0, 0, 1, 13'h010); lw[1] = hdr(2, 0, 1, 13'h011);
    run_list(2, 100, 100, "R11 clear R7 zero count");
    // R8 truncation mid payload under stall
    lw[0] = hdr(1, 4, 2, 13'h200); lw[1] = 32'h5; lw[2] = 32'h6;
    run_list(3, 100, 20, "R8 trunc");
    // R8 header as last word
    lw[0] = hdr(3, 2, 2, 13'h200);
    run_list(1, 100, 100, "R8 trunc header");
    // R7 empty list
    run_list(0, 100, 100, "R7 empty");
    // R9 random stalls over mixed lists
    for (int r = 0; r < 40; r++) begin
      int n = 0;
      int lim = $urandom_range(1, 40);
      while (n < lim) begin
        int rr = $urandom_range(0, 15);
        int md = (rr < 14) ? rr % 6 : 6 + (rr - 14);
        int c = $urandom_range(0, 4);
        lw[n] = hdr(md, c, $urandom_range(0, 7), $urandom);
        n++;
        if (md != 4 && md < 6)
          for (int k = 0; k < c; k++) begin lw[n] = $urandom & 32'h8000_FFFF; n++; end
      end
      if (n > 2 && $urandom_range(0, 3) == 0) n = n - $urandom_range(1, 2);
      run_list(n, $urandom_range(30, 100), $urandom_range(20, 100), "R9 random");
    end
    // R11 start while busy is ignored
    lw[0] = hdr(2, 3, 0, 13'h030); lw[1] = 32'h1; lw[2] = 32'h2; lw[3] = 32'h3;
    @(negedge clk_i); start_i = 1'b1; len_i = 16'd4;
    @(negedge clk_i); start_i = 1'b1; len_i = 16'd1; wr_ready_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      word_valid_i = 1'b1; word_i = lw[k];
      @(negedge clk_i);
    end
    word_valid_i = 1'b0;
    #1;
    check(!busy_o, "R11 busy start ignored, list ran full length", 64'(busy_o), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule